// File: doc/BRIEF.md
# Serial EEPROM Instruction Slave

This block models a small serial nonvolatile memory as seen from its four-wire host interface: a chip select, a serial clock, a serial data input and a serial data output. A ready/busy output is also provided. All inputs are sampled in a faster system clock domain, and rising edges of the serial clock are detected there. The host raises chip select, sends a start bit, a two-bit opcode and an address, and then either reads back a word or supplies one to be programmed.

The storage is a register array of `2**ADDR_W` words of `DATA_W` bits. Programming is protected by a sticky enable flag. Every programming instruction that is accepted holds the ready output low for `PROG_CYCLES` system clocks. This emulates a self-timed program cycle. Reset stands in for power-up.

Top module: `eeprom_serial_slave`

## Requirements
- R1: A frame starts once chip select is high. Zeros clocked before the first 1 are skipped. That 1 is the start bit, and it is followed by a 2-bit opcode and then `ADDR_W` address bits. All bits are sampled MSB first on rising edges of `sclk_i`.
- R2: For a READ, `do_o` drives a 0 dummy bit from the last address bit's edge. It then presents the word MSB first, one new bit on each later rising edge of `sclk_i`.
- R3: `do_o` is 1 while chip select is low and after the last read bit. It changes only on a detected `sclk_i` rising edge or when chip select drops.
- R4: After reset, programming is disabled, every array bit is 1 and `rdy_o` is 1.
- R5: WRITE, ERAL and WRAL have no effect on the array or on `rdy_o` while programming is disabled.
- R6: EWEN enables programming. The enable persists over any number of instructions until EWDS or reset.
- R7: READ returns the stored word whether programming is enabled or disabled.
- R8: An enabled WRITE stores its word after the last data bit. `rdy_o` then stays 0 for `PROG_CYCLES` system clocks and returns to 1.
- R9: ERAL sets every word to all ones. WRAL stores its data word in every location. Both hold `rdy_o` low like WRITE.
- R10: A frame whose header completes while `rdy_o` is 0 is discarded. It changes neither the array nor the enable, and a READ issued this way leaves `do_o` at 1.
- R11: A frame cut short by chip select falling before its last bit leaves the array, the enable and `rdy_o` untouched.
- R12: The opcode encodings are READ=10, WRITE=01, and 00 for the control group. Inside the control group the two top address bits select EWEN=11, EWDS=00, ERAL=10 and WRAL=01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-up) |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock, sampled by clk_i |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out, idle 1 |
| rdy_o | output | 1 | 1 = ready, 0 = programming in progress |

## Verification
Each serial bit edge is detected on the first system clock that sees `sclk_i` high. Every serial-side result therefore appears one clock after that edge. This covers the dummy bit after the last address bit, each further read bit, and the drop of `rdy_o` after the last data bit. The bench holds each serial clock phase for two system clocks and samples `do_o` and `rdy_o` on the falling system clock edge two cycles after it raises `sclk_i`. By that point each result is already due. The busy window is counted in system clocks from that sample until `rdy_o` returns high, and it must lie within three cycles below `PROG_CYCLES`, because part of the window has already elapsed before the count starts. Ignored instructions are checked by reading the affected word back and by confirming that `rdy_o` stays high.

// File: rtl/eeprom_serial_pkg.sv
package eeprom_serial_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_RD, ST_DATA, ST_DONE
  } rx_state_e;

  typedef enum logic [1:0] {
    OP_NONE, OP_WRITE, OP_FILL
  } prog_op_e;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_CTRL  = 2'b00;
  localparam logic [1:0] SUB_EN    = 2'b11;
  localparam logic [1:0] SUB_DIS   = 2'b00;
  localparam logic [1:0] SUB_ERASE = 2'b10;
  localparam logic [1:0] SUB_FILL  = 2'b01;
endpackage

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import eeprom_serial_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sclk_i,
  input  logic              di_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              do_o,
  output prog_op_e          op_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic              en_set_o,
  output logic              en_clr_o
);
  localparam int HDR_W = 2 + ADDR_W;
  localparam int MAXB  = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam int CW    = $clog2(MAXB + 1);

  rx_state_e         st_q;
  logic [CW-1:0]     cnt_q;
  logic              sclk_q;
  logic [HDR_W-1:0]  hdr_q;
  logic [DATA_W-1:0] dat_q;
  logic [DATA_W:0]   out_q;
  prog_op_e          kind_q;

  logic              rise;
  logic [HDR_W-1:0]  hdr_nx;
  logic [DATA_W-1:0] dat_nx;
  logic [1:0]        opc;
  logic [ADDR_W-1:0] adr;

  assign rise      = sclk_i & ~sclk_q;
  assign hdr_nx    = {hdr_q[HDR_W-2:0], di_i};
  assign dat_nx    = {dat_q[DATA_W-2:0], di_i};
  assign opc       = hdr_nx[HDR_W-1 -: 2];
  assign adr       = hdr_nx[ADDR_W-1:0];
  assign rd_addr_o = adr;
  assign do_o      = out_q[DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      sclk_q    <= 1'b0;
      hdr_q     <= '0;
      dat_q     <= '0;
      out_q     <= '1;
      kind_q    <= OP_NONE;
      op_o      <= OP_NONE;
      op_addr_o <= '0;
      op_data_o <= '0;
      en_set_o  <= 1'b0;
      en_clr_o  <= 1'b0;
    end else begin
      sclk_q   <= sclk_i;
      op_o     <= OP_NONE;
      en_set_o <= 1'b0;
      en_clr_o <= 1'b0;
      if (!cs_i) begin
        st_q  <= ST_IDLE;
        out_q <= '1;
      end else if (rise) begin
        unique case (st_q)
          ST_IDLE: if (di_i) begin
            st_q  <= ST_HDR;
            cnt_q <= '0;
          end
          ST_HDR: begin
            hdr_q <= hdr_nx;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(HDR_W - 1)) begin
              op_addr_o <= adr;
              cnt_q     <= '0;
              st_q      <= ST_DONE;
              if (!busy_i) begin
                unique case (opc)
                  OPC_READ: begin
                    st_q  <= ST_RD;
                    out_q <= {1'b0, rd_data_i};
                  end
                  OPC_WRITE: begin
                    st_q   <= ST_DATA;
                    kind_q <= OP_WRITE;
                  end
                  OPC_CTRL: begin
                    unique case (adr[ADDR_W-1 -: 2])
                      SUB_EN:    en_set_o <= 1'b1;
                      SUB_DIS:   en_clr_o <= 1'b1;
                      SUB_ERASE: begin
                        op_o      <= OP_FILL;
                        op_data_o <= '1;
                      end
                      default: begin
                        st_q   <= ST_DATA;
                        kind_q <= OP_FILL;
                      end
                    endcase
                  end
                  default: ;
                endcase
              end
            end
          end
          ST_RD: out_q <= {out_q[DATA_W-1:0], 1'b1};
          ST_DATA: begin
            dat_q <= dat_nx;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(DATA_W - 1)) begin
              op_o      <= kind_q;
              op_data_o <= dat_nx;
              st_q      <= ST_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int PROG_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic rdy_o
);
  localparam int TW = $clog2(PROG_CYCLES + 1);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= TW'(PROG_CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign rdy_o = (cnt_q == '0);
endmodule

// File: rtl/eeprom_word_array.sv
module eeprom_word_array #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              fill_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[i] <= '1;
      else if (fill_i)                             mem_q[i] <= wdata_i;
      else if (we_i && waddr_i == ADDR_W'(i))      mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/eeprom_serial_slave.sv
module eeprom_serial_slave
  import eeprom_serial_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int PROG_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic di_i,
  output logic do_o,
  output logic rdy_o
);
  prog_op_e          op;
  logic [ADDR_W-1:0] op_addr, rd_addr;
  logic [DATA_W-1:0] op_data, rd_data;
  logic              en_set, en_clr, prog_en_q;
  logic              arr_we, arr_fill, prog_start;

  serial_frame_rx #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rx (
    .clk_i, .rst_ni, .cs_i, .sclk_i, .di_i,
    .busy_i   (~rdy_o),
    .rd_data_i(rd_data),
    .rd_addr_o(rd_addr),
    .do_o,
    .op_o     (op),
    .op_addr_o(op_addr),
    .op_data_o(op_data),
    .en_set_o (en_set),
    .en_clr_o (en_clr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prog_en_q <= 1'b0;
    else if (en_set) prog_en_q <= 1'b1;
    else if (en_clr) prog_en_q <= 1'b0;
  end

  assign arr_we     = (op == OP_WRITE) && prog_en_q && rdy_o;
  assign arr_fill   = (op == OP_FILL)  && prog_en_q && rdy_o;
  assign prog_start = arr_we || arr_fill;

  eeprom_word_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_arr (
    .clk_i, .rst_ni,
    .we_i   (arr_we),
    .fill_i (arr_fill),
    .waddr_i(op_addr),
    .wdata_i(op_data),
    .raddr_i(rd_addr),
    .rdata_o(rd_data)
  );

  prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
    .clk_i, .rst_ni,
    .start_i(prog_start),
    .rdy_o
  );
endmodule

// File: rtl/eeprom_serial_slave_chk.sv
module eeprom_serial_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_i,
  input logic sclk_i,
  input logic do_o,
  input logic rdy_o,
  input logic prog_en,
  input logic prog_start,
  input logic en_set,
  input logic en_clr
);
  assert_idle_out_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> do_o);

  assert_out_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cs_i) && !($past(sclk_i) && !$past(sclk_i, 2))) |-> $stable(do_o));

  assert_locked_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_en |-> rdy_o);

  assert_busy_after_prog_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start |=> !rdy_o);

  assert_no_ctrl_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_o |-> !(en_set || en_clr));

  assert_enable_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_en && !en_clr) |=> prog_en);
endmodule

bind eeprom_serial_slave eeprom_serial_slave_chk u_chk (
  .clk_i, .rst_ni, .cs_i, .sclk_i, .do_o, .rdy_o,
  .prog_en   (prog_en_q),
  .prog_start(prog_start),
  .en_set    (en_set),
  .en_clr    (en_clr)
);

// File: tb/eeprom_serial_slave_bench.sv
module eeprom_serial_slave_bench;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int PC = 200;

  typedef struct packed {
    logic [2:0]    cmd;   // 0 rd,1 wr,2 eral,3 wral,4 ewen,5 ewds
    logic [AW-1:0] addr;
    logic [DW-1:0] data;  // write data or expected read data
    logic          busy;  // programming cycle expected
  } vec_t;

  localparam vec_t VECS [18] = '{
    '{3'd0, 4'h3, 8'hFF, 1'b0}, '{3'd1, 4'h3, 8'h55, 1'b0},
    '{3'd0, 4'h3, 8'hFF, 1'b0}, '{3'd4, 4'h0, 8'h00, 1'b0},
    '{3'd1, 4'h3, 8'hA5, 1'b1}, '{3'd0, 4'h3, 8'hA5, 1'b0},
    '{3'd1, 4'h0, 8'h3C, 1'b1}, '{3'd0, 4'h0, 8'h3C, 1'b0},
    '{3'd3, 4'h0, 8'h5A, 1'b1}, '{3'd0, 4'h7, 8'h5A, 1'b0},
    '{3'd0, 4'h3, 8'h5A, 1'b0}, '{3'd2, 4'h0, 8'h00, 1'b1},
    '{3'd0, 4'hF, 8'hFF, 1'b0}, '{3'd1, 4'hF, 8'h81, 1'b1},
    '{3'd5, 4'h0, 8'h00, 1'b0}, '{3'd1, 4'hF, 8'h00, 1'b0},
    '{3'd0, 4'hF, 8'h81, 1'b0}, '{3'd0, 4'h1, 8'hFF, 1'b0}
  };

  logic clk = 1'b0, rst_ni = 1'b0, cs = 1'b0, sclk = 1'b0, di = 1'b0;
  logic do_w, rdy_w;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  eeprom_serial_slave #(.DATA_W(DW), .ADDR_W(AW), .PROG_CYCLES(PC)) u_eeprom_serial_slave (
    .clk_i(clk), .rst_ni, .cs_i(cs), .sclk_i(sclk), .di_i(di), .do_o(do_w), .rdy_o(rdy_w)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    @(negedge clk); di = b; sclk = 1'b0;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (2) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic hdr(input logic [1:0] opc, input logic [AW-1:0] a, input int zeros);
    @(negedge clk); cs = 1'b1;
    for (int i = 0; i < zeros; i++) bit_out(1'b0);
    bit_out(1'b1);
    for (int i = 1; i >= 0; i--) bit_out(opc[i]);
    for (int i = AW - 1; i >= 0; i--) bit_out(a[i]);
  endtask

  task automatic frame_end();
    @(negedge clk); cs = 1'b0; di = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, input int zeros, output logic dmy, output logic [DW-1:0] d);
    hdr(2'b10, a, zeros);
    dmy = do_w;
    for (int i = DW - 1; i >= 0; i--) begin
      bit_out(1'b0);
      d[i] = do_w;
    end
  endtask

  task automatic check_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    logic dmy;
    logic [DW-1:0] d;
    rd(a, 0, dmy, d);
    frame_end();
    chk({req, " dummy bit"}, int'(dmy), 0);
    chk(req, int'(d), int'(exp));
  endtask

  // cmd: 1 wr, 2 eral, 3 wral, 4 ewen, 5 ewds
  task automatic prog(input logic [2:0] cmd, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic exp_busy, input bit wait_rdy, input string req);
    logic [1:0]    opc;
    logic [AW-1:0] ad;
    int            cnt;
    opc = (cmd == 3'd1) ? 2'b01 : 2'b00;
    ad  = a;
    case (cmd)
      3'd2: ad = {2'b10, {(AW-2){1'b0}}};
      3'd3: ad = {2'b01, {(AW-2){1'b0}}};
      3'd4: ad = {2'b11, {(AW-2){1'b0}}};
      3'd5: ad = {2'b00, {(AW-2){1'b0}}};
      default: ;
    endcase
    hdr(opc, ad, 0);
    if (cmd == 3'd1 || cmd == 3'd3)
      for (int i = DW - 1; i >= 0; i--) bit_out(d[i]);
    chk({req, " rdy after last bit"}, int'(rdy_w), exp_busy ? 0 : 1);
    if (exp_busy && wait_rdy) begin
      cnt = 0;
      while (!rdy_w && cnt < 4 * PC) begin
        @(negedge clk);
        cnt++;
      end
      chk({req, " busy length in range"}, int'(cnt >= PC - 3 && cnt <= PC), 1);
    end
    frame_end();
  endtask

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'd0: return "R2 R7 read";
      3'd1: return "R5 R8 write";
      3'd2: return "R9 eral";
      3'd3: return "R9 wral";
      3'd4: return "R6 R12 ewen";
      default: return "R6 ewds";
    endcase
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic          dmy;
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4 rdy after reset", int'(rdy_w), 1);
    chk("R3 do idle with cs low", int'(do_w), 1);

    foreach (VECS[k]) begin
      if (VECS[k].cmd == 3'd0) check_read(VECS[k].addr, VECS[k].data, req_of(VECS[k].cmd));
      else prog(VECS[k].cmd, VECS[k].addr, VECS[k].data, VECS[k].busy, 1'b1, req_of(VECS[k].cmd));
    end

    // R1: leading zeros before start bit, plus R3 idle after last read bit
    rd(4'hF, 2, dmy, d);
    chk("R1 leading zeros read", int'(d), 'h81);
    bit_out(1'b0);
    chk("R3 do after last read bit", int'(do_w), 1);
    frame_end();

    // R10: frames during busy are discarded
    prog(3'd4, 4'h0, 8'h00, 1'b0, 1'b1, "R6 ewen again");
    prog(3'd1, 4'h2, 8'h11, 1'b1, 1'b0, "R8 write no wait");
    prog(3'd1, 4'h5, 8'h22, 1'b1, 1'b0, "R10 write while busy");
    hdr(2'b10, 4'h2, 0);
    chk("R10 read while busy do", int'(do_w), 1);
    frame_end();
    while (!rdy_w) @(negedge clk);
    check_read(4'h5, 8'hFF, "R10 busy write discarded");
    check_read(4'h2, 8'h11, "R8 first write stored");

    // R11: cut-short write
    hdr(2'b01, 4'h9, 0);
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    frame_end();
    chk("R11 rdy after cut frame", int'(rdy_w), 1);
    check_read(4'h9, 8'hFF, "R11 cut frame discarded");

    // R4/R6: reset clears enable and array
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk); rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check_read(4'h2, 8'hFF, "R4 array ones after reset");
    prog(3'd1, 4'h2, 8'h77, 1'b0, 1'b1, "R6 write after reset ignored");
    check_read(4'h2, 8'hFF, "R5 locked write no effect");

    summary();
  end
endmodule